// File: doc/BRIEF.md
# SIMD Element Reverse Unit

This block takes a 32-bit vector permute instruction word together with a 128-bit source operand, decodes the word, and reverses the order of the elements inside each container of the operand. The instruction fields set the container width (16, 32 or 64 bits) and the element width (8, 16 or 32 bits). The vector width is 64 or 128 bits. Containers stay where they are in the vector. Only the element order inside each container changes.

An issue stage drives the instruction, the operand and a single-cycle strobe. One cycle later the unit returns the permuted vector, the two register indices taken from the word, an undefined-instruction flag and a valid strobe. The permutation is fixed wiring, selected by the decoded fields, so the latency never depends on the operand value.

Top module: `simd_elem_rev`

## Requirements
- R1: The word is accepted only when bit 31 = 0, bits 28..24 = 01110, bits 21..17 = 10000, bits 16..13 = 0000 and bits 11..10 = 10. Any other pattern raises the undefined flag.
- R2: The source index output carries word bits 9..5. The destination index output carries word bits 4..0.
- R3: The container width comes from {bit 12, bit 29}: 00 gives 64, 01 gives 32, 10 gives 16. The value 11 raises the undefined flag.
- R4: The element width is 8 shifted left by bits 23..22. When the container width is less than or equal to the element width, the undefined flag is raised.
- R5: Within each container, element i of the source goes to element position (elements per container − 1 − i). Each container keeps its own place in the vector.
- R6: With bit 30 = 0, only the low 64 bits are permuted and result bits 127..64 are zero. With bit 30 = 1, all 128 bits are permuted.
- R7: The valid output is high exactly one cycle after each input strobe and low otherwise. The latency is the same for every operand value.
- R8: While the undefined flag is high, the result output is all zeros.
- R9: Without a strobe, the result, index and undefined outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction and operand strobe |
| insn_i | input | 32 | Instruction word |
| src_i | input | 128 | Source vector operand |
| result_o | output | 128 | Permuted vector |
| rd_o | output | 5 | Destination register index |
| rn_o | output | 5 | Source register index |
| undef_o | output | 1 | Undefined-instruction flag |
| valid_o | output | 1 | Result strobe |

## Verification
Every output is due one clock edge after the strobe. The bench drives the inputs on a falling edge and samples the outputs on the next falling edge, which is half a period after the edge that loads them. To check R9, the bench keeps the strobe low for a cycle and compares the outputs again at the following falling edge. To check R7, it confirms that valid has dropped by then.

// File: rtl/simd_rev_pkg.sv
package simd_rev_pkg;
    localparam int INSN_W = 32;
    localparam int IDX_W  = 5;

    typedef struct packed {
        logic             match;
        logic             wide;
        logic [1:0]       csel;
        logic [1:0]       size;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
    } dec_t;
endpackage

// File: rtl/simd_rev_decode.sv
module simd_rev_decode
    import simd_rev_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o,
    output logic              undef_o
);
    logic [2:0] clog;
    logic [2:0] elog;

    always_comb begin
        dec_o.match = (insn_i[31] == 1'b0) &&
                      (insn_i[28:24] == 5'b01110) &&
                      (insn_i[21:17] == 5'b10000) &&
                      (insn_i[16:13] == 4'b0000) &&
                      (insn_i[11:10] == 2'b10);
        dec_o.wide = insn_i[30];
        dec_o.csel = {insn_i[12], insn_i[29]};
        dec_o.size = insn_i[23:22];
        dec_o.rn   = insn_i[9:5];
        dec_o.rd   = insn_i[4:0];
        clog       = 3'd6 - {1'b0, dec_o.csel};
        elog       = 3'd3 + {1'b0, dec_o.size};
        undef_o    = !dec_o.match || (dec_o.csel == 2'b11) || (clog <= elog);
    end
endmodule

// File: rtl/simd_rev_permute.sv
module simd_rev_permute #(
    parameter int VEC_W  = 128,
    parameter int HALF_W = 64
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic [1:0]       csel_i,
    input  logic [1:0]       size_i,
    input  logic             wide_i,
    output logic [VEC_W-1:0] res_o
);
    localparam int NCW = 3;
    localparam int NEW = 3;

    logic [VEC_W-1:0] perm [NCW][NEW];
    logic [1:0]       ci_sel;
    logic [VEC_W-1:0] picked;

    for (genvar ci = 0; ci < NCW; ci++) begin : g_c
        localparam int CW = 16 << ci;
        for (genvar ei = 0; ei < NEW; ei++) begin : g_e
            localparam int EW = 8 << ei;
            if (EW < CW) begin : g_ok
                logic [VEC_W-1:0] r;
                for (genvar b = 0; b < VEC_W; b++) begin : g_b
                    localparam int SRC = (b / CW) * CW
                                       + (CW / EW - 1 - (b % CW) / EW) * EW
                                       + (b % EW);
                    assign r[b] = src_i[SRC];
                end
                assign perm[ci][ei] = r;
            end else begin : g_na
                assign perm[ci][ei] = '0;
            end
        end
    end

    always_comb begin
        ci_sel = 2'd2 - csel_i;
        if (csel_i == 2'b11 || size_i == 2'b11) begin
            picked = '0;
        end else begin
            picked = perm[ci_sel][size_i];
        end
        res_o = picked;
        if (!wide_i) begin
            res_o[VEC_W-1:HALF_W] = '0;
        end
    end
endmodule

// File: rtl/simd_elem_rev.sv
module simd_elem_rev
    import simd_rev_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [INSN_W-1:0]  insn_i,
    input  logic [VEC_W-1:0]   src_i,
    output logic [VEC_W-1:0]   result_o,
    output logic [IDX_W-1:0]   rd_o,
    output logic [IDX_W-1:0]   rn_o,
    output logic               undef_o,
    output logic               valid_o
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rn;
        logic [VEC_W-1:0] result;
    } out_t;

    dec_t             dec;
    logic             dec_undef;
    logic [VEC_W-1:0] perm_res;
    out_t             st_d;
    out_t             st_q;

    simd_rev_decode u_dec (
        .insn_i  (insn_i),
        .dec_o   (dec),
        .undef_o (dec_undef)
    );

    simd_rev_permute #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_perm (
        .src_i  (src_i),
        .csel_i (dec.csel),
        .size_i (dec.size),
        .wide_i (dec.wide),
        .res_o  (perm_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            st_d.undef  = dec_undef;
            st_d.rd     = dec.rd;
            st_d.rn     = dec.rn;
            st_d.result = dec_undef ? '0 : perm_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign rd_o     = st_q.rd;
    assign rn_o     = st_q.rn;
    assign undef_o  = st_q.undef;
    assign valid_o  = st_q.valid;

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && insn_i[31]) |=> undef_o); // R1
    AST_INDEX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (rd_o == $past(insn_i[4:0]) && rn_o == $past(insn_i[9:5]))); // R2
    AST_CSEL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && insn_i[12] && insn_i[29]) |=> undef_o); // R3
    AST_SIZE_TOO_BIG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && insn_i[23:22] == 2'b11) |=> undef_o); // R4
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !insn_i[30]) |=> (result_o[VEC_W-1:HALF_W] == '0)); // R6
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> valid_o); // R7
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !valid_o); // R7
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> (result_o == '0)); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(result_o) && $stable(undef_o) && $stable(rd_o))); // R9
endmodule

// File: tb/sim_simd_elem_rev.sv
module sim_simd_elem_rev;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [31:0]  insn_i = '0;
    logic [127:0] src_i = '0;
    logic [127:0] result_o;
    logic [4:0]   rd_o;
    logic [4:0]   rn_o;
    logic         undef_o;
    logic         valid_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    simd_elem_rev u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .insn_i(insn_i),
        .src_i(src_i), .result_o(result_o), .rd_o(rd_o), .rn_o(rn_o),
        .undef_o(undef_o), .valid_o(valid_o)
    );

    // each entry: {q, u, o0, size[1:0]}
    localparam logic [4:0] VECS [15] = '{
        5'b1_0_0_00, 5'b1_0_0_01, 5'b1_0_0_10, 5'b1_0_0_11,
        5'b1_1_0_00, 5'b1_1_0_01, 5'b1_1_0_10,
        5'b1_0_1_00, 5'b1_0_1_01,
        5'b1_1_1_00,
        5'b0_0_0_00, 5'b0_0_0_10, 5'b0_1_0_01, 5'b0_0_1_00, 5'b0_1_0_00
    };

    function automatic logic [31:0] mk(input logic q, input logic u, input logic [1:0] sz,
                                       input logic o0, input logic [4:0] rn, input logic [4:0] rd);
        return {1'b0, q, u, 5'b01110, sz, 5'b10000, 4'b0000, o0, 2'b10, rn, rd};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] op, input int w, input int c, input int e);
        logic [127:0] res = '0;
        int n = c / e;
        for (int k = 0; k < w / c; k++)
            for (int i = 0; i < n; i++)
                for (int j = 0; j < e; j++)
                    res[k*c + (n-1-i)*e + j] = op[k*c + i*e + j];
        return res;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] op);
        @(negedge clk);
        in_valid_i = 1'b1; insn_i = w; src_i = op;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [127:0] ops [2];
        ops[0] = 128'h0f0e0d0c0b0a09080706050403020100;
        ops[1] = 128'hdeadbeef_01234567_89abcdef_cafef00d;
        repeat (3) @(negedge clk);
        chk(valid_o == 0 && result_o == 0 && undef_o == 0 && rd_o == 0, "R7 reset", result_o, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 15; v++) begin
            for (int p = 0; p < 2; p++) begin
                logic q, u, o0;
                logic [1:0] sz;
                int c, e, w;
                bit ud;
                logic [127:0] exp;
                {q, u, o0, sz} = VECS[v];
                c  = ({o0, u} == 2'b11) ? 0 : (64 >> {o0, u});
                e  = 8 << sz;
                ud = (c <= e);
                w  = q ? 128 : 64;
                exp = ud ? '0 : model(ops[p], w, c, e);
                issue(mk(q, u, sz, o0, 5'(v), 5'(31 - v)), ops[p]);
                chk(valid_o == 1, "R7 valid", {127'b0, valid_o}, 1);
                chk(undef_o == ud, "R3/R4 undef", {127'b0, undef_o}, {127'b0, ud});
                chk(result_o == exp, "R5 R6 R8 result", result_o, exp);
                chk(rn_o == 5'(v) && rd_o == 5'(31 - v), "R2 index", {rn_o, rd_o}, {5'(v), 5'(31 - v)});
            end
        end

        // R9: hold without strobe, R7: valid low
        issue(mk(1, 0, 2'b01, 0, 5'd3, 5'd4), ops[1]);
        begin
            logic [127:0] held;
            held = result_o;
            src_i = ops[0]; insn_i = mk(1, 1, 2'b00, 1, 5'd9, 5'd9);
            @(negedge clk);
            chk(valid_o == 0, "R7 idle", {127'b0, valid_o}, 0);
            chk(result_o == held && rd_o == 5'd4 && rn_o == 5'd3 && undef_o == 0, "R9 hold", result_o, held);
        end

        // R1: opcode mismatches
        issue(mk(1, 0, 2'b00, 0, 5'd1, 5'd2) | 32'h8000_0000, ops[0]);
        chk(undef_o == 1 && result_o == 0, "R1 bit31 R8", result_o, 0);
        issue(mk(1, 0, 2'b00, 0, 5'd1, 5'd2) ^ 32'h0000_0400, ops[0]);
        chk(undef_o == 1 && result_o == 0, "R1 bits11..10", result_o, 0);
        issue(mk(1, 0, 2'b00, 0, 5'd1, 5'd2) | 32'h0002_0000, ops[0]);
        chk(undef_o == 1, "R1 bits21..17", {127'b0, undef_o}, 1);
        issue(mk(1, 0, 2'b00, 0, 5'd1, 5'd2) | 32'h0000_2000, ops[0]);
        chk(undef_o == 1, "R1 bits16..13", {127'b0, undef_o}, 1);

        // R7: back-to-back strobes
        @(negedge clk);
        in_valid_i = 1'b1; insn_i = mk(1, 0, 2'b00, 1, 5'd0, 5'd0); src_i = ops[0];
        @(negedge clk);
        chk(valid_o == 1 && result_o == model(ops[0], 128, 16, 8), "R7 b2b first", result_o, model(ops[0], 128, 16, 8));
        insn_i = mk(0, 0, 2'b10, 0, 5'd0, 5'd0); src_i = ops[1];
        @(negedge clk);
        in_valid_i = 1'b0;
        chk(valid_o == 1 && result_o == model(ops[1], 64, 64, 32), "R7 b2b second", result_o, model(ops[1], 64, 64, 32));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule